// File: doc/BRIEF.md
# Paced Serial Transmit Queue with Pin-Driven Enable

This block sits between the packet sources of a host-controller link and the UART bit serialiser. Reply bytes and forwarded event or ACL packets are pushed into a circular byte queue. The queue drains toward the serialiser no faster than one byte per baud interval. That interval is a clock-cycle divisor written through a register port.

Two control pins govern the device. A falling edge on the reset pin returns the whole block to its reset state. The device starts releasing bytes only after the pin pair moves into the both-high state. A two-bit modem-status register models simplified RTS/CTS handshaking for the driver.

For a forwarded packet the pusher tags each byte with the packet kind. The block inserts the kind byte ahead of the payload, and it appends a zero pad byte whenever that keeps the packet length even.

Top module: `hci_tx_pacer`

## Requirements
- R1: `tx_valid` is high exactly when the device is enabled, the pacing slot is open and the queue holds a byte. Bytes leave in push order, one per cycle in which `tx_valid` and `tx_ready` are both high. Nothing is released while the device is disabled.
- R2: Two successive transfers are at least the divisor number of cycles apart. When `tx_ready` stays high and the queue stays non-empty, they are exactly that far apart.
- R3: After reset the divisor is `DEFAULT_DIV`. A divisor write replaces it, and a written value of 0 behaves as 1.
- R4: `push_tag` 2 (ACL) or 4 (event) on a byte with `push_first` high queues a kind byte equal to the tag, zero-extended to 8 bits, ahead of that data byte. Any other tag queues the data byte unchanged and never pads.
- R5: A forwarded packet whose kind byte plus payload would be odd in length is followed by one 0x00 byte, queued with the byte marked `push_last`.
- R6: Bytes that do not fit in the `DEPTH`-byte queue are dropped. When two bytes arrive together and only one fits, the earlier one is kept. `overflow` goes high and stays high.
- R7: A high-to-low change on `pin_rst` empties the queue, clears `overflow`, restores `DEFAULT_DIV`, restores the modem-status reset value and disables the device. In the next cycle `framer_clear` pulses high for exactly one cycle.
- R8: The device becomes enabled only when {`pin_wake`,`pin_rst`} changes into 2'b11 from any other value. Raising `pin_wake` alone does not enable it.
- R9: The modem status has CTS in bit 1 and RTS in bit 0 and resets to 2'b10. A modem-status write stores the written bits. A divisor write sets CTS.
- R10: A modem-status write that clears RTS while RTS was set also clears CTS. When RTS was already clear, the written CTS value is stored as given.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | A byte is offered to the queue this cycle |
| push_first | input | 1 | Byte is the first payload byte of a forwarded packet |
| push_last | input | 1 | Byte is the last payload byte of a forwarded packet |
| push_tag | input | 3 | Packet kind: 2 ACL, 4 event, anything else verbatim |
| push_data | input | 8 | Byte to queue |
| tx_ready | input | 1 | Serialiser can take a byte |
| tx_valid | output | 1 | A paced byte is on offer |
| tx_data | output | 8 | Byte on offer |
| pin_rst | input | 1 | Device reset pin, active on its falling edge |
| pin_wake | input | 1 | Second control pin |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | CNT_W | Baud interval in clock cycles |
| ms_we | input | 1 | Modem-status write strobe |
| ms_wdata | input | 2 | Modem status to write, {CTS,RTS} |
| ms_rdata | output | 2 | Current modem status, {CTS,RTS} |
| overflow | output | 1 | Sticky flag: a queued byte was dropped |
| framer_clear | output | 1 | One-cycle pulse telling the receive framer to restart |

## Verification
The queue is loaded with verbatim reply bytes and with forwarded packets of one, two, three and four payload bytes of both kinds. This separates correct kind-byte insertion from pad insertion and parity tracking across packets. Pacing is measured at the default divisor, at a small written divisor and at divisor 0. A stalled serialiser shows that the offered byte is held. Filling the queue until a two-byte write only half fits shows which byte survives. Toggling the pins in both orders, and a reset fall with data queued, separates the enable rule from the reset rule.

// File: rtl/hci_txq_pkg.sv
// Shared encodings and types for the paced transmit queue.
package hci_txq_pkg;
    localparam logic [2:0] TAG_ACL = 3'd2;
    localparam logic [2:0] TAG_EVT = 3'd4;

    // Up to two bytes written into the queue in one cycle.
    typedef struct packed {
        logic [1:0] cnt;
        logic [7:0] b0;
        logic [7:0] b1;
    } wr_req_t;

    // Modem status: bit 1 CTS, bit 0 RTS.
    typedef struct packed {
        logic cts;
        logic rts;
    } modem_t;
endpackage

// File: rtl/hci_txq_pad.sv
// Turns one pushed byte into zero, one or two queue writes.
// Inserts the kind byte in front of a forwarded packet and a zero pad after
// an odd-length one. Assumes push_tag is constant within a packet and that
// every forwarded packet has push_first on its first byte.
module hci_txq_pad
    import hci_txq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push_valid,
    input  logic       push_first,
    input  logic       push_last,
    input  logic [2:0] push_tag,
    input  logic [7:0] push_data,
    output wr_req_t    req
);
    logic odd_q;
    logic fwd;

    assign fwd = (push_tag == TAG_ACL) || (push_tag == TAG_EVT);

    // Choose the bytes to write for this push.
    always_comb begin
        req = '0;
        if (push_valid) begin
            if (!fwd) begin
                req.cnt = 2'd1;
                req.b0  = push_data;
            end else if (push_first) begin
                req.cnt = 2'd2;
                req.b0  = {5'b0, push_tag};
                req.b1  = push_data;
            end else if (push_last && odd_q) begin
                req.cnt = 2'd2;
                req.b0  = push_data;
                req.b1  = 8'h00;
            end else begin
                req.cnt = 2'd1;
                req.b0  = push_data;
            end
        end
    end

    // Track whether the payload pushed so far has an odd byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            odd_q <= 1'b0;
        end else if (push_valid && fwd) begin
            if (push_last)       odd_q <= 1'b0;
            else if (push_first) odd_q <= 1'b1;
            else                 odd_q <= ~odd_q;
        end
    end
endmodule

// File: rtl/hci_txq_ring.sv
// Circular byte queue with a two-byte write port and a one-byte read port.
// DEPTH must be a power of two. Writes beyond free space are dropped and
// latch a sticky overflow flag. Pop is only asserted when not empty.
module hci_txq_ring
    import hci_txq_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  wr_req_t    req,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       empty,
    output logic       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [CW-1:0] free;
    logic [1:0]    n_wr;
    logic          short;

    assign free  = CW'(DEPTH) - cnt;
    assign short = CW'(req.cnt) > free;
    assign empty = (cnt == '0);
    assign rd_data = mem[rp];

    // Limit the write count to the space left.
    always_comb n_wr = short ? free[1:0] : req.cnt;

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (n_wr != 2'd0) mem[wp] <= req.b0;
        if (n_wr == 2'd2) mem[wp + AW'(1)] <= req.b1;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            wp  <= wp + AW'(n_wr);
            rp  <= rp + AW'(pop);
            cnt <= cnt + CW'(n_wr) - CW'(pop);
        end
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) overflow <= 1'b0;
        else if (short)      overflow <= 1'b1;
    end
endmodule

// File: rtl/hci_txq_baud.sv
// Baud-interval timer. The slot is open when the countdown is zero. A pop
// reloads it with div-1, so the next pop comes div cycles later at the
// earliest. A divisor of zero behaves as one.
module hci_txq_baud #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] div,
    input  logic             pop,
    output logic             slot_open
);
    logic [CNT_W-1:0] left;

    assign slot_open = (left == '0);

    // Count down to the next open slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)   left <= '0;
        else if (pop)          left <= (div == '0) ? '0 : div - CNT_W'(1);
        else if (left != '0)   left <= left - CNT_W'(1);
    end
endmodule

// File: rtl/hci_txq_ctl.sv
// Pin handling, divisor register and modem-status register.
// Pins are assumed synchronous to clk. A fall of pin_rst produces the flush
// strobe. Entering the both-high pin state enables the device.
module hci_txq_ctl
    import hci_txq_pkg::*;
#(
    parameter int          CNT_W       = 32,
    parameter int unsigned DEFAULT_DIV = 200_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_rst,
    input  logic             pin_wake,
    input  logic             div_we,
    input  logic [CNT_W-1:0] div_wdata,
    input  logic             ms_we,
    input  logic [1:0]       ms_wdata,
    output logic             flush,
    output logic             en,
    output logic             framer_clear,
    output logic [CNT_W-1:0] div_q,
    output modem_t           modem_q
);
    logic [1:0] pins, pins_q;
    logic       rise11;

    assign pins   = {pin_wake, pin_rst};
    assign flush  = pins_q[0] & ~pin_rst;
    assign rise11 = (pins == 2'b11) && (pins_q != 2'b11);

    // Remember the previous pin state.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= 2'b00;
        else        pins_q <= pins;
    end

    // Enable on entry to both-high, drop on reset fall.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) en <= 1'b0;
        else if (rise11)     en <= 1'b1;
    end

    // One-cycle framer restart pulse after a reset fall.
    always_ff @(posedge clk) begin
        if (!rst_n) framer_clear <= 1'b0;
        else        framer_clear <= flush;
    end

    // Baud divisor register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) div_q <= CNT_W'(DEFAULT_DIV);
        else if (div_we)     div_q <= div_wdata;
    end

    // Modem status with the RTS-drop rule; a divisor write wins on CTS.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            modem_q <= '{cts: 1'b1, rts: 1'b0};
        end else begin
            if (ms_we) begin
                modem_q.rts <= ms_wdata[0];
                modem_q.cts <= ms_wdata[1] & ~(modem_q.rts & ~ms_wdata[0]);
            end
            if (div_we) modem_q.cts <= 1'b1;
        end
    end
endmodule

// File: rtl/hci_tx_pacer.sv
// Top of the paced transmit queue: push-side formatting, byte queue,
// baud timer and pin/register control.
module hci_tx_pacer
    import hci_txq_pkg::*;
#(
    parameter int          DEPTH       = 4096,
    parameter int          CNT_W       = 32,
    parameter int unsigned DEFAULT_DIV = 200_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic             push_first,
    input  logic             push_last,
    input  logic [2:0]       push_tag,
    input  logic [7:0]       push_data,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             pin_rst,
    input  logic             pin_wake,
    input  logic             div_we,
    input  logic [CNT_W-1:0] div_wdata,
    input  logic             ms_we,
    input  logic [1:0]       ms_wdata,
    output logic [1:0]       ms_rdata,
    output logic             overflow,
    output logic             framer_clear
);
    wr_req_t          req;
    logic             flush, en, slot_open, empty, pop;
    logic [CNT_W-1:0] div_q;
    modem_t           modem_q;

    assign tx_valid = en & slot_open & ~empty;
    assign pop      = tx_valid & tx_ready;
    assign ms_rdata = modem_q;

    hci_txq_ctl #(.CNT_W(CNT_W), .DEFAULT_DIV(DEFAULT_DIV)) u_ctl (
        .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .pin_wake(pin_wake),
        .div_we(div_we), .div_wdata(div_wdata), .ms_we(ms_we),
        .ms_wdata(ms_wdata), .flush(flush), .en(en),
        .framer_clear(framer_clear), .div_q(div_q), .modem_q(modem_q)
    );

    hci_txq_pad u_pad (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
        .push_first(push_first), .push_last(push_last), .push_tag(push_tag),
        .push_data(push_data), .req(req)
    );

    hci_txq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req(req), .pop(pop),
        .rd_data(tx_data), .empty(empty), .overflow(overflow)
    );

    hci_txq_baud #(.CNT_W(CNT_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .flush(flush), .div(div_q), .pop(pop),
        .slot_open(slot_open)
    );
endmodule

// File: rtl/hci_tx_pacer_chk.sv
// Property checker for the paced transmit queue, bound to the top module.
module hci_tx_pacer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             en,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             pin_rst,
    input logic             pin_wake,
    input logic             div_we,
    input logic [CNT_W-1:0] div_q,
    input logic             ms_we,
    input logic [1:0]       ms_wdata,
    input logic [1:0]       ms_rdata,
    input logic             overflow
);
    logic [CNT_W-1:0] gap;
    logic             armed;
    logic [1:0]       pq;
    logic             pop;

    assign pop = tx_valid & tx_ready;

    // Cycles since the last transfer, armed while the divisor is unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= '0;
            armed <= 1'b0;
            pq    <= 2'b00;
        end else begin
            pq <= {pin_wake, pin_rst};
            if (pop) begin
                gap   <= CNT_W'(1);
                armed <= 1'b1;
            end else if (gap != '1) begin
                gap <= gap + CNT_W'(1);
            end
            if (div_we || flush) armed <= 1'b0;
        end
    end

    // R2
    pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && armed) |-> (gap >= ((div_q == '0) ? CNT_W'(1) : div_q)));

    // R8
    enable_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({pin_wake, pin_rst} == 2'b11 && pq != 2'b11) |=> en);

    // R10
    cts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_we && ms_rdata[0] && !ms_wdata[0] && !div_we && !flush) |=> !ms_rdata[1]);

    // R7
    reset_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!tx_valid && !en && !overflow && ms_rdata == 2'b10));

    // R6
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_data)));
endmodule

bind hci_tx_pacer hci_tx_pacer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .en(en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .pin_rst(pin_rst),
    .pin_wake(pin_wake), .div_we(div_we), .div_q(div_q), .ms_we(ms_we),
    .ms_wdata(ms_wdata), .ms_rdata(ms_rdata), .overflow(overflow)
);

// File: tb/hci_tx_pacer_test.sv
`timescale 1ns/1ps
module hci_tx_pacer_test;
    localparam int DEPTH = 32;
    localparam int CNT_W = 16;
    localparam int DDIV  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0, push_first = 1'b0, push_last = 1'b0;
    logic [2:0]       push_tag = 3'd0;
    logic [7:0]       push_data = 8'h00;
    logic             tx_ready = 1'b0;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             pin_rst = 1'b0, pin_wake = 1'b0;
    logic             div_we = 1'b0;
    logic [CNT_W-1:0] div_wdata = '0;
    logic             ms_we = 1'b0;
    logic [1:0]       ms_wdata = 2'b00;
    logic [1:0]       ms_rdata;
    logic             overflow, framer_clear;

    int total = 0;
    int fails = 0;
    logic [7:0] got [64];
    int         gaps [64];

    always #2.5 clk = ~clk;

    hci_tx_pacer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DEFAULT_DIV(DDIV)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_first(push_first),
        .push_last(push_last), .push_tag(push_tag), .push_data(push_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .pin_rst(pin_rst), .pin_wake(pin_wake), .div_we(div_we),
        .div_wdata(div_wdata), .ms_we(ms_we), .ms_wdata(ms_wdata),
        .ms_rdata(ms_rdata), .overflow(overflow), .framer_clear(framer_clear)
    );

    // Pushes: {tag[2:0], first, last, data[7:0]}
    localparam logic [12:0] PUSH_TAB [12] = '{
        {3'd0, 1'b0, 1'b0, 8'h11}, {3'd0, 1'b0, 1'b0, 8'h22},
        {3'd2, 1'b1, 1'b1, 8'hA1},
        {3'd4, 1'b1, 1'b0, 8'hE1}, {3'd4, 1'b0, 1'b1, 8'hE2},
        {3'd2, 1'b1, 1'b0, 8'h31}, {3'd2, 1'b0, 1'b0, 8'h32}, {3'd2, 1'b0, 1'b1, 8'h33},
        {3'd4, 1'b1, 1'b0, 8'h41}, {3'd4, 1'b0, 1'b0, 8'h42}, {3'd4, 1'b0, 1'b0, 8'h43},
        {3'd4, 1'b0, 1'b1, 8'h44}
    };
    // Expected stream: {kind[1:0], byte}; kind 0 order (R1), 1 type byte (R4), 2 pad (R5)
    localparam logic [9:0] EXP_TAB [18] = '{
        {2'd0, 8'h11}, {2'd0, 8'h22}, {2'd1, 8'h02}, {2'd0, 8'hA1},
        {2'd1, 8'h04}, {2'd0, 8'hE1}, {2'd0, 8'hE2}, {2'd2, 8'h00},
        {2'd1, 8'h02}, {2'd0, 8'h31}, {2'd0, 8'h32}, {2'd0, 8'h33},
        {2'd1, 8'h04}, {2'd0, 8'h41}, {2'd0, 8'h42}, {2'd0, 8'h43},
        {2'd0, 8'h44}, {2'd2, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] tag, input logic f, input logic l, input logic [7:0] d);
        push_valid = 1'b1; push_tag = tag; push_first = f; push_last = l; push_data = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Take n bytes with tx_ready high, recording bytes and spacing.
    task automatic collect(input int n);
        int w;
        w = 0;
        tx_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            while (!tx_valid && w < 400) begin @(negedge clk); w++; end
            got[i]  = tx_data;
            gaps[i] = w;
            @(negedge clk);
            w = 1;
        end
        tx_ready = 1'b0;
    endtask

    task automatic write_ms(input logic [1:0] v);
        ms_we = 1'b1; ms_wdata = v;
        @(negedge clk);
        ms_we = 1'b0;
    endtask

    task automatic write_div(input int v);
        div_we = 1'b1; div_wdata = CNT_W'(v);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    initial begin
        #500us;
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1, R9, R6, R7)
        chk("R1 reset tx_valid", tx_valid, 0);
        chk("R9 reset modem", ms_rdata, 2'b10);
        chk("R6 reset overflow", overflow, 0);
        chk("R7 reset framer_clear", framer_clear, 0);

        // Table load while disabled (R1)
        for (int i = 0; i < 12; i++)
            push(PUSH_TAB[i][12:10], PUSH_TAB[i][9], PUSH_TAB[i][8], PUSH_TAB[i][7:0]);
        tx_ready = 1'b1;
        cycles(20);
        chk("R1 no release while disabled", tx_valid, 0);
        tx_ready = 1'b0;

        // Wake pin alone does not enable (R8)
        pin_wake = 1'b1;
        cycles(4);
        chk("R8 wake alone stays disabled", tx_valid, 0);
        pin_rst = 1'b1;
        cycles(2);
        chk("R8 enabled on entry to 11", tx_valid, 1);

        // Drain the table at the default interval (R1, R4, R5, R2, R3)
        collect(18);
        for (int i = 0; i < 18; i++) begin
            case (EXP_TAB[i][9:8])
                2'd1:    chk("R4 kind byte", got[i], EXP_TAB[i][7:0]);
                2'd2:    chk("R5 zero pad", got[i], EXP_TAB[i][7:0]);
                default: chk("R1 byte order", got[i], EXP_TAB[i][7:0]);
            endcase
            if (i > 0) chk("R2 R3 default interval", gaps[i], DDIV);
        end

        // Stall holds offer (R11)
        push(3'd0, 1'b0, 1'b0, 8'h5A);
        push(3'd0, 1'b0, 1'b0, 8'h5B);
        cycles(12);
        chk("R11 offer present", tx_valid, 1);
        chk("R11 offer data", tx_data, 8'h5A);
        cycles(3);
        chk("R11 still offered", tx_valid, 1);
        chk("R11 data held", tx_data, 8'h5A);

        // Modem status (R9, R10)
        write_ms(2'b11);
        chk("R9 modem write", ms_rdata, 2'b11);
        write_ms(2'b10);
        chk("R10 RTS drop clears CTS", ms_rdata, 2'b00);
        write_ms(2'b10);
        chk("R10 no drop keeps CTS", ms_rdata, 2'b10);
        write_ms(2'b01);
        chk("R9 modem write CTS low", ms_rdata, 2'b01);
        write_div(3);
        chk("R9 divisor write sets CTS", ms_rdata, 2'b11);

        // Written divisor (R3)
        collect(2);
        chk("R1 stalled byte first", got[0], 8'h5A);
        chk("R1 stalled byte second", got[1], 8'h5B);
        chk("R3 written interval", gaps[1], 3);

        // Divisor zero behaves as one (R3)
        write_div(0);
        push(3'd0, 1'b0, 1'b0, 8'hC1);
        push(3'd0, 1'b0, 1'b0, 8'hC2);
        push(3'd0, 1'b0, 1'b0, 8'hC3);
        collect(3);
        chk("R3 zero divisor gap", gaps[1], 1);
        chk("R3 zero divisor gap b", gaps[2], 1);
        chk("R3 zero divisor data", got[2], 8'hC3);

        // Overflow keeps earlier byte of a pair (R6)
        for (int i = 0; i < DEPTH - 1; i++) push(3'd0, 1'b0, 1'b0, 8'(i));
        chk("R6 no overflow when fitting", overflow, 0);
        push(3'd2, 1'b1, 1'b0, 8'h77);
        chk("R6 overflow set", overflow, 1);
        push(3'd0, 1'b0, 1'b0, 8'h99);
        collect(DEPTH);
        chk("R6 last fitting raw byte", got[DEPTH-2], 8'(DEPTH - 2));
        chk("R6 earlier byte of pair kept", got[DEPTH-1], 8'h02);
        chk("R6 dropped bytes absent", tx_valid, 0);
        chk("R6 overflow sticky", overflow, 1);

        // Reset pin fall (R7)
        write_ms(2'b01);
        push(3'd0, 1'b0, 1'b0, 8'hD1);
        pin_rst = 1'b0;
        @(negedge clk);
        chk("R7 framer_clear pulse", framer_clear, 1);
        chk("R7 overflow cleared", overflow, 0);
        chk("R7 modem restored", ms_rdata, 2'b10);
        chk("R7 disabled", tx_valid, 0);
        @(negedge clk);
        chk("R7 framer_clear one cycle", framer_clear, 0);
        pin_rst = 1'b1;
        cycles(2);
        chk("R7 queue emptied", tx_valid, 0);
        push(3'd0, 1'b0, 1'b0, 8'hE7);
        push(3'd0, 1'b0, 1'b0, 8'hE8);
        collect(2);
        chk("R7 data after reset", got[1], 8'hE8);
        chk("R7 default divisor restored", gaps[1], DDIV);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule